// File: doc/BRIEF.md
# Cache Line Pin Register File

This block is a small file of pin registers. It keeps a cache line resident between a read-modify-write load and the store that completes it. Each register holds a line tag and a reference count. A load that pins a line either raises the count of the register already holding that tag, or claims a free register with a count of one. A store that unpins the line, or the squash of a speculative pinning load, lowers the count. The register is released when its count returns to zero.

Before the cache evicts a line, it presents the victim tag. The block answers in the same cycle whether that eviction must wait. A pin request that cannot be served is answered with a stall, and the requester holds it until a later cycle. A stall happens when every register is occupied by other tags, or when the matching count is already at its ceiling. An unpin or squash whose tag is not held raises an error flag and leaves the registers untouched. The register count is a parameter, and one register is a legal configuration.

Top module: `line_pin_regs`

## Requirements
- R1: After reset no register is in use: no victim tag is blocked, and no stall or error is raised while the inputs are idle.
- R2: A pin whose tag is not held takes a free register (the lowest-indexed one) with a count of one. NREG distinct tags can be held at the same time.
- R3: A pin whose tag is already held adds one to that register's count. The tag stays held until an equal number of decrements arrive.
- R4: An unpin of a held tag subtracts one from its count. At zero the register is freed and the tag no longer blocks eviction.
- R5: A squash of a held tag has the same effect on the count and on freeing as an unpin.
- R6: `pin_stall` is high in the same cycle as a pin request if the tag is not held and no register is free, or if the tag is held with a count of 2**CNT_W-1. A stalled pin changes no register.
- R7: `evict_blocked` is high in the same cycle if `evict_req` is high and either a held register carries `evict_tag` or an accepted pin for that tag arrives in that cycle. It is low whenever `evict_req` is low.
- R8: `unmatched_err` is high in the same cycle as an unpin or squash whose tag is not held. That event changes no register.
- R9: If an unpin and a squash name the same held tag in one cycle, and its count (plus a pin accepted for it in that cycle) is one, the unpin is applied and the squash is dropped with `unmatched_err` raised.
- R10: With NREG = 1 the block pins one tag, stalls a pin of a second tag, and accepts that second tag once the first is released.
- R11: A pin and an unpin of the same held tag in one cycle leave its count unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pin_req | input | 1 | Pinning load issued this cycle |
| pin_tag | input | TAG_W | Line tag of the pinning load |
| unpin_req | input | 1 | Unpinning store issued this cycle |
| unpin_tag | input | TAG_W | Line tag of the unpinning store |
| squash_req | input | 1 | Squash of a speculative pinning load |
| squash_tag | input | TAG_W | Line tag of the squashed load |
| evict_req | input | 1 | Eviction check requested |
| evict_tag | input | TAG_W | Victim line tag |
| pin_stall | output | 1 | Pin request not served; retry later |
| evict_blocked | output | 1 | Victim line is pinned; eviction must wait |
| unmatched_err | output | 1 | Unpin or squash did not match a held tag |

## Verification
The coincidences that matter are an eviction query arriving together with a pin of the same tag, and decrements arriving together with a pin. The harder cases are an unpin and a squash naming one register with a count of one, and a pin and an unpin of the same line. The bench drives pin, unpin, squash and eviction traffic over a narrow tag space so that these overlaps happen often. It judges each cycle's stall, block and error outputs against a count model built from the requirements. Between steps it sweeps every victim tag to expose which lines remain held.

// File: rtl/line_pin_regs.sv
module line_pin_regs #(
  parameter int NREG  = 8,
  parameter int TAG_W = 24,
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pin_req,
  input  logic [TAG_W-1:0] pin_tag,
  input  logic             unpin_req,
  input  logic [TAG_W-1:0] unpin_tag,
  input  logic             squash_req,
  input  logic [TAG_W-1:0] squash_tag,
  input  logic             evict_req,
  input  logic [TAG_W-1:0] evict_tag,
  output logic             pin_stall,
  output logic             evict_blocked,
  output logic             unmatched_err
);

  localparam logic [CNT_W-1:0] CMAX = '1;
  localparam logic [CNT_W-1:0] CONE = CNT_W'(1);

  logic [NREG-1:0]             vld_q;
  logic [NREG-1:0][TAG_W-1:0]  tag_q;
  logic [NREG-1:0][CNT_W-1:0]  cnt_q;

  logic [NREG-1:0] hit_p, hit_u, hit_s, hit_e, at_max, at_one;
  logic [NREG-1:0] alloc, inc, dec_u, dec_s;

  for (genvar i = 0; i < NREG; i++) begin : g_match
    assign hit_p[i]  = vld_q[i] && (tag_q[i] == pin_tag);
    assign hit_u[i]  = unpin_req && vld_q[i] && (tag_q[i] == unpin_tag);
    assign hit_s[i]  = squash_req && vld_q[i] && (tag_q[i] == squash_tag);
    assign hit_e[i]  = vld_q[i] && (tag_q[i] == evict_tag);
    assign at_max[i] = cnt_q[i] == CMAX;
  end

  always_comb begin
    logic taken;
    taken = 1'b0;
    alloc = '0;
    for (int i = 0; i < NREG; i++) begin
      if (!vld_q[i] && !taken) begin
        alloc[i] = 1'b1;
        taken    = 1'b1;
      end
    end
  end

  logic pin_hit, pin_go, conflict;

  assign pin_hit   = |hit_p;
  assign pin_stall = pin_req && (pin_hit ? |(hit_p & at_max) : ~|alloc);
  assign pin_go    = pin_req && !pin_stall;

  for (genvar i = 0; i < NREG; i++) begin : g_step
    assign inc[i]    = pin_go && (pin_hit ? hit_p[i] : alloc[i]);
    assign at_one[i] = (cnt_q[i] == CONE) && !inc[i];
    assign dec_u[i]  = hit_u[i];
    assign dec_s[i]  = hit_s[i] && !conflict;
  end

  assign conflict      = |(hit_u & hit_s & at_one);
  assign unmatched_err = (unpin_req && ~|hit_u) || (squash_req && ~|hit_s) || conflict;
  assign evict_blocked = evict_req && (|hit_e || (pin_go && (pin_tag == evict_tag)));

  for (genvar i = 0; i < NREG; i++) begin : g_reg
    logic [CNT_W-1:0] cnt_d;
    assign cnt_d = cnt_q[i] + CNT_W'(inc[i]) - CNT_W'(dec_u[i]) - CNT_W'(dec_s[i]);

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        vld_q[i] <= 1'b0;
        cnt_q[i] <= '0;
        tag_q[i] <= '0;
      end else begin
        vld_q[i] <= cnt_d != '0;
        cnt_q[i] <= cnt_d;
        if (inc[i] && !vld_q[i]) tag_q[i] <= pin_tag;
      end
    end
  end

endmodule

// File: rtl/line_pin_regs_chk.sv
module line_pin_regs_chk #(
  parameter int NREG  = 8,
  parameter int TAG_W = 24,
  parameter int CNT_W = 4
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       pin_req,
  input logic [TAG_W-1:0]           pin_tag,
  input logic                       unpin_req,
  input logic                       squash_req,
  input logic                       evict_req,
  input logic [TAG_W-1:0]           evict_tag,
  input logic                       pin_stall,
  input logic                       evict_blocked,
  input logic                       unmatched_err,
  input logic [NREG-1:0]            vld,
  input logic [NREG-1:0][TAG_W-1:0] tags,
  input logic [NREG-1:0][CNT_W-1:0] cnts
);

  logic [TAG_W-1:0] last_pin_tag;
  logic [NREG-1:0]  held_last, held_victim;

  always_ff @(posedge clk) last_pin_tag <= pin_tag;

  for (genvar i = 0; i < NREG; i++) begin : g_cmp
    assign held_last[i]   = vld[i] && (tags[i] == last_pin_tag);
    assign held_victim[i] = vld[i] && (tags[i] == evict_tag);

    p_live_count_r3: assert property (@(posedge clk) disable iff (!rst_n)
      vld[i] |-> cnts[i] != '0);
  end

  p_one_alloc_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(vld) <= $countones($past(vld)) + 1);

  p_stall_freeze_r6: assert property (@(posedge clk) disable iff (!rst_n)
    pin_req && pin_stall && !unpin_req && !squash_req |=> $stable(vld) && $stable(cnts));

  p_err_freeze_r8: assert property (@(posedge clk) disable iff (!rst_n)
    unmatched_err && !pin_req && !(unpin_req && squash_req) |=> $stable(vld) && $stable(cnts));

  p_pin_held_r2: assert property (@(posedge clk) disable iff (!rst_n)
    pin_req && !pin_stall && !unpin_req && !squash_req |=> |held_last);

  p_block_pinned_r7: assert property (@(posedge clk) disable iff (!rst_n)
    evict_req && |held_victim |-> evict_blocked);

  p_block_needs_query_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !evict_req |-> !evict_blocked);

endmodule

bind line_pin_regs line_pin_regs_chk #(.NREG(NREG), .TAG_W(TAG_W), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .pin_req(pin_req), .pin_tag(pin_tag),
  .unpin_req(unpin_req), .squash_req(squash_req),
  .evict_req(evict_req), .evict_tag(evict_tag),
  .pin_stall(pin_stall), .evict_blocked(evict_blocked), .unmatched_err(unmatched_err),
  .vld(vld_q), .tags(tag_q), .cnts(cnt_q)
);

// File: tb/tb_line_pin_regs.sv
module tb_line_pin_regs;
  localparam int N = 4;
  localparam int TW = 3;
  localparam int CW = 2;
  localparam int CMAXV = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic pr, ur, sr, er;
  logic [TW-1:0] pt, ut, st, et;
  logic stall, blk, err;

  line_pin_regs #(.NREG(N), .TAG_W(TW), .CNT_W(CW)) dut (
    .clk(clk), .rst_n(rst_n), .pin_req(pr), .pin_tag(pt), .unpin_req(ur), .unpin_tag(ut),
    .squash_req(sr), .squash_tag(st), .evict_req(er), .evict_tag(et),
    .pin_stall(stall), .evict_blocked(blk), .unmatched_err(err));

  logic p1, u1, e1;
  logic [TW-1:0] pt1, ut1, et1;
  logic stall1, blk1, err1;

  line_pin_regs #(.NREG(1), .TAG_W(TW), .CNT_W(CW)) dut1 (
    .clk(clk), .rst_n(rst_n), .pin_req(p1), .pin_tag(pt1), .unpin_req(u1), .unpin_tag(ut1),
    .squash_req(1'b0), .squash_tag(ut1), .evict_req(e1), .evict_tag(et1),
    .pin_stall(stall1), .evict_blocked(blk1), .unmatched_err(err1));

  int checks = 0;
  int fails = 0;
  int mt[N];
  int mc[N];

  task automatic chk(string req, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%b expected=%b", req, act, exp);
    end
  endtask

  function automatic int find(int t);
    for (int i = 0; i < N; i++) if (mc[i] > 0 && mt[i] == t) return i;
    return -1;
  endfunction

  function automatic int first_free();
    for (int i = 0; i < N; i++) if (mc[i] == 0) return i;
    return -1;
  endfunction

  function automatic bit held(int t);
    return find(t) >= 0;
  endfunction

  task automatic step(bit p, int ptg, bit u, int utg, bit s, int stg, bit e, int etg);
    int pm, um, sm, pidx;
    bit xs, pgo, conf, xe, xb;
    @(negedge clk);
    pr = p; pt = TW'(ptg); ur = u; ut = TW'(utg);
    sr = s; st = TW'(stg); er = e; et = TW'(etg);
    #2;
    pm = p ? find(ptg) : -1;
    xs = p && (pm >= 0 ? mc[pm] == CMAXV : first_free() < 0);
    pgo = p && !xs;
    pidx = pm >= 0 ? pm : first_free();
    um = u ? find(utg) : -1;
    sm = s ? find(stg) : -1;
    conf = u && s && um >= 0 && um == sm && (mc[um] + ((pgo && pidx == um) ? 1 : 0)) == 1;
    xe = (u && um < 0) || (s && sm < 0) || conf;
    xb = e && (held(etg) || (pgo && ptg == etg));
    chk("R6 stall", stall, xs);
    chk(conf ? "R9 err" : "R8 err", err, xe);
    chk("R7 block", blk, xb);
    if (pgo) begin
      if (pm < 0) mt[pidx] = ptg;
      mc[pidx]++;
    end
    if (um >= 0) mc[um]--;
    if (sm >= 0 && !conf) mc[sm]--;
  endtask

  task automatic idle();
    step(0, 0, 0, 0, 0, 0, 0, 0);
  endtask

  task automatic sweep(string req);
    @(negedge clk);
    pr = 0; ur = 0; sr = 0; er = 1;
    for (int t = 0; t < (1 << TW); t++) begin
      et = TW'(t);
      #1;
      chk(req, blk, held(t));
    end
    er = 0;
  endtask

  initial begin
    #(20 * 200000);
    fails++;
    checks++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    pr = 0; ur = 0; sr = 0; er = 0; pt = 0; ut = 0; st = 0; et = 0;
    p1 = 0; u1 = 0; e1 = 0; pt1 = 0; ut1 = 0; et1 = 0;
    for (int i = 0; i < N; i++) begin mt[i] = 0; mc[i] = 0; end
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    // R1 reset state
    #2;
    chk("R1 stall", stall, 1'b0);
    chk("R1 err", err, 1'b0);
    sweep("R1 nothing held");

    // R2 fill all registers
    for (int t = 1; t <= N; t++) step(1, t, 0, 0, 0, 0, 0, 0);
    sweep("R2 held set");
    step(1, 5, 0, 0, 0, 0, 0, 0);
    chk("R6 full", stall, 1'b1);

    // R3 count to ceiling, then stall on max
    step(1, 1, 0, 0, 0, 0, 0, 0);
    step(1, 1, 0, 0, 0, 0, 0, 0);
    step(1, 1, 0, 0, 0, 0, 0, 0);
    chk("R6 count max", stall, 1'b1);
    step(0, 0, 1, 1, 0, 0, 0, 0);
    step(0, 0, 1, 1, 0, 0, 0, 0);
    sweep("R3 still held");
    step(0, 0, 1, 1, 0, 0, 1, 1);
    chk("R3 held until last", blk, 1'b1);
    sweep("R4 freed at zero");
    chk("R4 tag1 free", held(1), 1'b0);

    // R5 squash frees
    step(0, 0, 0, 0, 1, 2, 0, 0);
    sweep("R5 squash freed");

    // R8 unmatched unpin
    step(0, 0, 1, 6, 0, 0, 0, 0);
    chk("R8 unmatched", err, 1'b1);
    sweep("R8 no change");

    // R9 unpin and squash on a count-one register
    step(1, 7, 0, 0, 0, 0, 0, 0);
    step(0, 0, 1, 7, 1, 7, 0, 0);
    chk("R9 dropped squash", err, 1'b1);
    sweep("R9 single decrement");

    // R11 pin and unpin of same tag
    step(0, 0, 1, 3, 0, 0, 0, 0);
    step(1, 3, 0, 0, 0, 0, 0, 0);
    step(1, 3, 1, 3, 0, 0, 0, 0);
    step(0, 0, 0, 0, 0, 0, 1, 3);
    chk("R11 still held", blk, 1'b1);

    // R7 same-cycle pin and eviction query
    step(1, 6, 0, 0, 0, 0, 1, 6);
    chk("R7 same cycle", blk, 1'b1);
    step(0, 0, 0, 0, 0, 0, 0, 6);
    chk("R7 no query", blk, 1'b0);

    // mixed traffic
    for (int n = 0; n < 4000; n++) begin
      step($urandom_range(0, 1) == 1, $urandom_range(0, 7),
           $urandom_range(0, 2) == 0, $urandom_range(0, 7),
           $urandom_range(0, 3) == 0, $urandom_range(0, 7),
           $urandom_range(0, 1) == 1, $urandom_range(0, 7));
      if (n % 40 == 0) sweep("R2 R3 R4 R5 mixed held set");
    end
    idle();

    // R10 single register
    @(negedge clk); p1 = 1; pt1 = 2; #2; chk("R10 first pin", stall1, 1'b0);
    @(negedge clk); pt1 = 4; #2; chk("R10 second stalls", stall1, 1'b1);
    @(negedge clk); p1 = 0; e1 = 1; et1 = 2; #2; chk("R10 held", blk1, 1'b1);
    @(negedge clk); e1 = 0; u1 = 1; ut1 = 2; #2; chk("R10 unpin ok", err1, 1'b0);
    @(negedge clk); u1 = 0; p1 = 1; pt1 = 4; #2; chk("R10 reuse", stall1, 1'b0);
    @(negedge clk); p1 = 0; e1 = 1; et1 = 4; #2; chk("R10 new held", blk1, 1'b1);
    @(negedge clk); e1 = 0;

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule